// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Controller

This block gathers eleven one-cycle timer event strobes into two 8-bit status flag registers. Each flag has an enable bit in the same position of a matching 8-bit mask register. When any flag is set and its mask bit is also set, the block raises one interrupt request. That request appears on a registered 3-bit priority output, at a level that software programs.

Software clears a flag in two steps. First it reads the flag while the flag is set, which arms that bit. Then it writes a zero to that bit. If a new event for the same flag arrives after the read, the bit is disarmed. The flag therefore survives the write and needs a fresh read before it can be cleared. A small synchronous register bus reaches every register. It can access each register as a single byte, or each flag pair or mask pair as one 16-bit word.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Event strobe `evtIn[i]` sets a flag on the next clock edge. For i = 0..7 the flag is at word bit i+8 (flag register 1 is the high byte). `evtIn[8]` sets word bit 7, `evtIn[9]` sets word bit 5 and `evtIn[10]` sets word bit 4 (flag register 2 is the low byte).
- R2: In the low byte, bits 3..0 and bit 6 of both the flag word and the mask word always read 0, and writes to them are ignored.
- R3: After reset, all flags, all mask bits and the priority level read 0, and `irqLevel` is 0.
- R4: Addresses are decoded as follows: `busAddr` 0 selects the flag word, 1 selects the mask word and 2 selects the level (bits 2..0). `byteEn[1]` selects the high byte and `byteEn[0]` selects the low byte. A byte lane that is not selected reads 0 and is not written. A read arms only the flags in the lanes it selects.
- R5: A flag clears when software writes 0 to it after it was read as 1 through the bus.
- R6: Software can never set a flag, and writing 1 to a flag has no effect. Writing 0 to a flag that has not been read as 1 since its last clear leaves it unchanged.
- R7: An event that arrives between the qualifying read and the write keeps its flag set. A further read is then required before a write of 0 can clear it.
- R8: When an event strobe and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: `irqLevel` is registered. It equals the programmed level one cycle after any flag is set together with its mask bit, and otherwise it is 0. A level of 0 disables the output.
- R10: A set flag whose mask bit is 0 produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 11 | One-cycle timer event strobes |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select |
| byteEn | input | 2 | Byte lane enables (bit 1 = high byte) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational) |
| irqLevel | output | 3 | Registered request priority |

## Verification
The bench sweeps all eleven event sources and checks that each one lands in its own bit and clears through the read-then-write sequence. If the arm step were missing, a blind zero write would wipe a flag. If a re-arriving event did not disarm its bit, a flag would be lost when an event lands between the read and the write. If the write took priority over a same-cycle event, that event would vanish. A byte-lane check catches a design that arms flags in lanes it never read. A sweep of all eight levels, with the mask on and off, catches a request that leaks through a cleared mask or that ignores a level of 0.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int LVL_W   = 3;
  localparam int NUM_EVT = 11;
  localparam logic [WORD_W-1:0] FLAG_VALID = 16'hFFB0;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_LVL  = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic [1:0] rdEn;
    logic [1:0] rdSel;
    logic [1:0] rdFlag;
    logic [1:0] wrFlag;
    logic [1:0] wrMask;
    logic       wrLvl;
  } busCtl_t;

  function automatic int evtPos(input int i);
    if (i < BYTE_W) return i + BYTE_W;
    case (i)
      8:       return 7;
      9:       return 5;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tmr_irq_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [1:0] byteEn,
  output busCtl_t    ctl
);
  logic rdOp, wrOp;

  always_comb begin
    rdOp       = busSel & ~busWr;
    wrOp       = busSel & busWr;
    ctl        = '0;
    ctl.rdSel  = busAddr;
    ctl.rdEn   = rdOp ? byteEn : 2'b00;
    ctl.rdFlag = (rdOp && busAddr == ADDR_FLAG) ? byteEn : 2'b00;
    ctl.wrFlag = (wrOp && busAddr == ADDR_FLAG) ? byteEn : 2'b00;
    ctl.wrMask = (wrOp && busAddr == ADDR_MASK) ? byteEn : 2'b00;
    ctl.wrLvl  = wrOp && busAddr == ADDR_LVL && byteEn[0];
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  busCtl_t            ctl,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic [WORD_W-1:0]  flagVec,
  output logic [WORD_W-1:0]  maskVec,
  output logic [LVL_W-1:0]   lvlQ,
  output logic [LVL_W-1:0]   irqLevel
);
  logic [WORD_W-1:0] evtMap, armQ, flagQ, maskQ;
  logic [WORD_W-1:0] rdLaneF, wrLaneF, wrLaneM, rdLane;

  always_comb begin
    evtMap = '0;
    for (int i = 0; i < NUM_EVT; i++) evtMap[evtPos(i)] = evtMap[evtPos(i)] | evtIn[i];
  end

  assign rdLaneF = {{BYTE_W{ctl.rdFlag[1]}}, {BYTE_W{ctl.rdFlag[0]}}};
  assign wrLaneF = {{BYTE_W{ctl.wrFlag[1]}}, {BYTE_W{ctl.wrFlag[0]}}};
  assign wrLaneM = {{BYTE_W{ctl.wrMask[1]}}, {BYTE_W{ctl.wrMask[0]}}};
  assign rdLane  = {{BYTE_W{ctl.rdEn[1]}},   {BYTE_W{ctl.rdEn[0]}}};

  for (genvar g = 0; g < WORD_W; g++) begin : gBit
    if (FLAG_VALID[g]) begin : gLive
      logic clrHit;
      assign clrHit = wrLaneF[g] & ~wrData[g] & armQ[g];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          flagQ[g] <= 1'b0;
          armQ[g]  <= 1'b0;
          maskQ[g] <= 1'b0;
        end else begin
          flagQ[g] <= evtMap[g] | (flagQ[g] & ~clrHit);
          if (evtMap[g] || clrHit) armQ[g] <= 1'b0;
          else if (rdLaneF[g] && flagQ[g]) armQ[g] <= 1'b1;
          if (wrLaneM[g]) maskQ[g] <= wrData[g];
        end
      end
    end else begin : gTie
      assign flagQ[g] = 1'b0;
      assign armQ[g]  = 1'b0;
      assign maskQ[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ     <= '0;
      irqLevel <= '0;
    end else begin
      if (ctl.wrLvl) lvlQ <= wrData[LVL_W-1:0];
      irqLevel <= (|(flagQ & maskQ)) ? lvlQ : '0;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      ADDR_FLAG: rdData = flagQ & rdLane;
      ADDR_MASK: rdData = maskQ & rdLane;
      ADDR_LVL:  rdData = {{(WORD_W-LVL_W){1'b0}}, lvlQ} & rdLane;
      default:   rdData = '0;
    endcase
  end

  assign flagVec = flagQ;
  assign maskVec = maskQ;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [10:0]  evtIn,
  input  logic         busSel,
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  input  logic [1:0]   byteEn,
  input  logic [15:0]  wrData,
  output logic [15:0]  rdData,
  output logic [2:0]   irqLevel
);
  busCtl_t            ctl;
  logic [WORD_W-1:0]  flagVec, maskVec;
  logic [LVL_W-1:0]   lvlQ;

  tmr_irq_ctl u_ctl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .byteEn(byteEn), .ctl(ctl)
  );

  tmr_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evtIn(evtIn), .wrData(wrData),
    .rdData(rdData), .flagVec(flagVec), .maskVec(maskVec), .lvlQ(lvlQ),
    .irqLevel(irqLevel)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtIn,
  input logic [WORD_W-1:0]  flagVec,
  input logic [WORD_W-1:0]  maskVec,
  input logic [LVL_W-1:0]   lvlQ,
  input logic [LVL_W-1:0]   irqLevel
);
  logic [WORD_W-1:0] evtMapC;
  always_comb begin
    evtMapC = '0;
    for (int i = 0; i < NUM_EVT; i++) evtMapC[evtPos(i)] = evtMapC[evtPos(i)] | evtIn[i];
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (|evtMapC) |=> ((flagVec & $past(evtMapC)) == $past(evtMapC))); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec | maskVec) & ~FLAG_VALID) == '0); // R2
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagVec & ~$past(flagVec) & ~$past(evtMapC)) == '0)); // R6
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (|evtMapC) |=> ((flagVec & $past(evtMapC)) != '0)); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> ($past(lvlQ) == irqLevel && $past(|(flagVec & maskVec)))); // R9
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & maskVec) == '0) |=> (irqLevel == '0)); // R10
endmodule

bind tmr_irq_ctrl tmr_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .flagVec(flagVec), .maskVec(maskVec),
  .lvlQ(lvlQ), .irqLevel(irqLevel)
);

// File: tb/sim_tmr_irq_ctrl.sv
module sim_tmr_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] evtIn = '0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0, byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [2:0]  irqLevel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .irqLevel(irqLevel)
  );

  function automatic int bitOf(input int i);
    if (i < 8) return i + 8;
    return (i == 8) ? 7 : (i == 9) ? 5 : 4;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busRd(input logic [1:0] a, input logic [1:0] be, output logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a; byteEn = be;
    #1 d = rdData;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic busWrT(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d,
                        input logic [10:0] ev);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; byteEn = be; wrData = d; evtIn = ev;
    @(negedge clk);
    busSel = 0; busWr = 0; evtIn = '0;
  endtask

  task automatic pulse(input logic [10:0] ev);
    @(negedge clk); evtIn = ev;
    @(negedge clk); evtIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R3 reset state
    busRd(2'd0, 2'b11, d); chk("R3 flags", d, 16'h0000);
    busRd(2'd1, 2'b11, d); chk("R3 masks", d, 16'h0000);
    busRd(2'd2, 2'b11, d); chk("R3 level", d, 16'h0000);
    chk("R3 irq", {13'd0, irqLevel}, 16'h0000);

    // R1/R5 sweep every source: set, read-arm, write zero, cleared
    for (int i = 0; i < 11; i++) begin
      pulse(11'(1 << i));
      busRd(2'd0, 2'b11, d); chk("R1 event position", d, 16'(1 << bitOf(i)));
      busWrT(2'd0, 2'b11, ~16'(1 << bitOf(i)), '0);
      busRd(2'd0, 2'b11, d); chk("R5 read-then-write clears", d, 16'h0000);
    end

    // R6 blind zero write and write of ones
    pulse(11'h001);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R6 unread zero write keeps flag", d, 16'h0100);
    busWrT(2'd0, 2'b11, 16'hFFFF, '0);
    busRd(2'd0, 2'b11, d); chk("R6 writing ones no effect", d, 16'h0100);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R5 clear after arm", d, 16'h0000);

    // R7 event between read and write
    pulse(11'h004);
    busRd(2'd0, 2'b11, d);
    pulse(11'h004);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b01, d); chk("R7 low lane read zero", d, 16'h0000);
    busRd(2'd1, 2'b00, d);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b10, d); chk("R7 flag survives, needs fresh read", d, 16'h0400);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R7 clear after fresh read", d, 16'h0000);

    // R8 event and clearing write same cycle
    pulse(11'h400);
    busRd(2'd0, 2'b11, d);
    busWrT(2'd0, 2'b11, 16'h0000, 11'h400);
    busRd(2'd0, 2'b11, d); chk("R8 event wins over clear", d, 16'h0010);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R8 cleanup", d, 16'h0000);

    // R2 reserved bits
    busWrT(2'd1, 2'b11, 16'hFFFF, '0);
    busRd(2'd1, 2'b11, d); chk("R2 mask reserved zero", d, 16'hFFB0);
    pulse(11'h7FF);
    busRd(2'd0, 2'b11, d); chk("R2 flag reserved zero", d, 16'hFFB0);
    busWrT(2'd0, 2'b11, 16'h0000, '0);

    // R4 byte lanes
    busWrT(2'd1, 2'b10, 16'h1234, '0);
    busRd(2'd1, 2'b11, d); chk("R4 high byte write", d, 16'h12B0);
    busWrT(2'd1, 2'b01, 16'h5634, '0);
    busRd(2'd1, 2'b11, d); chk("R4 low byte write", d, 16'h1230);
    busRd(2'd1, 2'b01, d); chk("R4 unselected lane reads zero", d, 16'h0030);
    pulse(11'h101);
    busRd(2'd0, 2'b01, d); chk("R4 low byte flag read", d, 16'h0080);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R4 only read lane armed", d, 16'h0100);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    busRd(2'd0, 2'b11, d); chk("R4 cleanup", d, 16'h0000);

    // R9/R10 level sweep with mask off and on
    pulse(11'h008);
    for (int l = 0; l < 8; l++) begin
      busWrT(2'd1, 2'b11, 16'h0000, '0);
      busWrT(2'd2, 2'b01, 16'(l), '0);
      @(negedge clk);
      chk("R10 masked flag no request", {13'd0, irqLevel}, 16'h0000);
      busWrT(2'd1, 2'b11, 16'h0800, '0);
      @(negedge clk);
      chk("R9 request level", {13'd0, irqLevel}, 16'(l));
    end
    busRd(2'd0, 2'b11, d);
    busWrT(2'd0, 2'b11, 16'h0000, '0);
    @(negedge clk);
    chk("R9 cleared flag drops request", {13'd0, irqLevel}, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule